// File: doc/BRIEF.md
# DMA Channel Register Set with Trigger Aliases

This block keeps the programmable state of a single DMA channel: a read pointer, a write pointer, a transfer length held both as a stored reload value and as a live down-counter, and a small control word. Software reaches this state through a 64-byte window. The window is made of four 16-byte groups. Each group holds the same four registers in a different order. The last word of every group is a trigger, so a burst of four word writes can program a channel and start it with its final write.

The data-moving engine sits outside this block. It receives a one-cycle start pulse, a busy level and the two current pointers. It reports each finished read beat on `rd_done` and each finished write beat on `wr_done`. On those strobes this block advances the pointers by the beat size and counts the length down. An `abort` pulse ends a run early. No data streams through the block, so it has no valid/ready interface. Every pin is a plain control or status level, or a strobe that is sampled on the rising clock edge.

A debug word outside the window returns the reload value, which is the length the next run will use.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, every register reads zero, `busy` and `start` are low, and both pointer outputs are zero.
- R2: The window offset is decoded with group = addr[5:4] and word = addr[3:2]. The word order in each group is:
  - group 0: read pointer, write pointer, count, control
  - group 1: control, read pointer, write pointer, count
  - group 2: control, count, read pointer, write pointer
  - group 3: control, write pointer, count, read pointer

  Control uses bits [1:0] for the size code, bit 2 for read-pointer increment enable and bit 3 for write-pointer increment enable. Its other bits read as zero. Any address that is neither in 0x000–0x03F nor equal to 0x804 reads zero.
- R3: A nonzero write to word 3 of any group (0x0C, 0x1C, 0x2C, 0x3C) while idle does two things. It writes that register. It also loads the live count at the same clock edge, after which `busy` is high and `start` is high for exactly one cycle.
- R4: A zero write to a trigger word updates only the addressed register. It produces no start and no change to `busy`.
- R5: A count write outside group 1's word 3 changes only the reload value. A nonzero write to the count trigger (0x1C) loads the written value as the live count and also as the reload value. A trigger through any other word loads the live count from the stored reload value.
- R6: Reading the count word returns the live count, zero-extended. While busy, each `wr_done` lowers the live count by one. `busy` falls in the cycle after the count reaches zero.
- R7: While busy, each `rd_done` advances the read pointer and each `wr_done` advances the write pointer. The step is 1 byte for size code 0, 2 bytes for code 1, and 4 bytes for codes 2 and 3. A pointer whose increment-enable bit is clear does not move. Strobes that arrive while idle have no effect.
- R8: Offset 0x804 reads the reload value. Because the reload value is kept, each later trigger starts a run of the same length.
- R9: A trigger that arrives while busy does not start a run and does not change the live count. The register write it carries still takes effect.
- R10: `abort` clears `busy` and the live count at the next edge and leaves the reload value unchanged. If a trigger arrives in the same cycle, `abort` wins.
- R11: A trigger whose loaded length is zero produces no `start` and leaves `busy` low.
- R12: A bus write to a pointer takes priority over the increment of that pointer in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | RA_W | Register byte address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational from `reg_addr` |
| rd_done | input | 1 | One read beat finished |
| wr_done | input | 1 | One write beat finished |
| abort | input | 1 | Cancel the current run |
| start | output | 1 | One-cycle pulse when a run begins |
| busy | output | 1 | A run is in progress |
| rd_ptr | output | DW | Next read address |
| wr_ptr | output | DW | Next write address |

## Verification
The assertions check several properties on every cycle:
- a start pulse only comes out of an idle state and is always paired with `busy`;
- `busy` only falls through the last write beat or an abort;
- every write beat while busy lowers the live count by one;
- an abort always leaves the count at zero;
- idle strobes never move a pointer.

Other behaviour is shown only by the bench scenarios. These include the alias map across all 64 offsets, the pointer step for each size code and increment setting, the difference between a count write and a count trigger, and the repeat of the reload length across triggers.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    ROLE_RD   = 2'd0,
    ROLE_WR   = 2'd1,
    ROLE_CNT  = 2'd2,
    ROLE_CTRL = 2'd3
  } role_e;

  localparam int CTRL_W      = 4;
  localparam int CTRL_RD_INC = 2;
  localparam int CTRL_WR_INC = 3;

  // Word order of each 16-byte alias group; word 3 is always the trigger.
  function automatic role_e role_of(input logic [1:0] grp, input logic [1:0] word);
    role_e r;
    case ({grp, word})
      4'h0: r = ROLE_RD;   4'h1: r = ROLE_WR;   4'h2: r = ROLE_CNT;  4'h3: r = ROLE_CTRL;
      4'h4: r = ROLE_CTRL; 4'h5: r = ROLE_RD;   4'h6: r = ROLE_WR;   4'h7: r = ROLE_CNT;
      4'h8: r = ROLE_CTRL; 4'h9: r = ROLE_CNT;  4'hA: r = ROLE_RD;   4'hB: r = ROLE_WR;
      4'hC: r = ROLE_CTRL; 4'hD: r = ROLE_WR;   4'hE: r = ROLE_CNT;  default: r = ROLE_RD;
    endcase
    return r;
  endfunction

  function automatic logic [2:0] step_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_chan_decode.sv
module dma_chan_decode
  import dma_chan_pkg::*;
#(
  parameter int RA_W    = 12,
  parameter int DBG_OFF = 'h804
) (
  input  logic [RA_W-1:0] addr,
  output logic            win_hit,
  output logic            dbg_hit,
  output logic            trig,
  output role_e           role
);
  localparam int WIN_BITS = 6;

  assign win_hit = (addr[RA_W-1:WIN_BITS] == '0);
  assign dbg_hit = (addr == RA_W'(DBG_OFF));
  assign trig    = win_hit && (addr[3:2] == 2'd3);
  assign role    = role_of(addr[5:4], addr[3:2]);
endmodule

// File: rtl/dma_addr_ptr.sv
module dma_addr_ptr #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          adv,
  input  logic [2:0]    step,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (adv)  q <= q + DW'(step);
  end
endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_wr,
  input  logic          trig_cnt,
  input  logic          trig_other,
  input  logic [CW-1:0] wval,
  input  logic          dec,
  input  logic          abort,
  output logic [CW-1:0] live,
  output logic [CW-1:0] reload,
  output logic          busy,
  output logic          start
);
  logic          go;
  logic [CW-1:0] next_len;

  assign go       = (trig_cnt || trig_other) && !busy && !abort;
  assign next_len = trig_cnt ? wval : reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live   <= '0;
      reload <= '0;
      busy   <= 1'b0;
      start  <= 1'b0;
    end else begin
      start <= 1'b0;
      if (cnt_wr) reload <= wval;
      if (abort) begin
        busy <= 1'b0;
        live <= '0;
      end else if (go) begin
        live  <= next_len;
        busy  <= (next_len != '0);
        start <= (next_len != '0);
      end else if (busy && dec) begin
        live <= live - 1'b1;
        if (live == CW'(1)) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int DW   = 32,
  parameter int CW   = 16,
  parameter int RA_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RA_W-1:0] reg_addr,
  input  logic            reg_we,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            rd_done,
  input  logic            wr_done,
  input  logic            abort,
  output logic            start,
  output logic            busy,
  output logic [DW-1:0]   rd_ptr,
  output logic [DW-1:0]   wr_ptr
);
  logic          win_hit, dbg_hit, trig_word;
  role_e         role;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CW-1:0] cnt_live, cnt_reload;
  logic          wr_win, trig_hit, trig_cnt, trig_other;
  logic [2:0]    step;

  dma_chan_decode #(.RA_W(RA_W)) u_dec (
    .addr(reg_addr), .win_hit(win_hit), .dbg_hit(dbg_hit),
    .trig(trig_word), .role(role)
  );

  assign wr_win     = reg_we && win_hit;
  assign trig_hit   = wr_win && trig_word && (reg_wdata != '0);
  assign trig_cnt   = trig_hit && (role == ROLE_CNT);
  assign trig_other = trig_hit && (role != ROLE_CNT);
  assign step       = step_bytes(ctrl_q[1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_win && role == ROLE_CTRL) ctrl_q <= reg_wdata[CTRL_W-1:0];
  end

  dma_addr_ptr #(.DW(DW)) u_rd_ptr (
    .clk(clk), .rst_n(rst_n),
    .load(wr_win && role == ROLE_RD), .load_val(reg_wdata),
    .adv(busy && rd_done && ctrl_q[CTRL_RD_INC]), .step(step), .q(rd_ptr)
  );

  dma_addr_ptr #(.DW(DW)) u_wr_ptr (
    .clk(clk), .rst_n(rst_n),
    .load(wr_win && role == ROLE_WR), .load_val(reg_wdata),
    .adv(busy && wr_done && ctrl_q[CTRL_WR_INC]), .step(step), .q(wr_ptr)
  );

  dma_xfer_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .cnt_wr(wr_win && role == ROLE_CNT), .trig_cnt(trig_cnt), .trig_other(trig_other),
    .wval(reg_wdata[CW-1:0]), .dec(wr_done), .abort(abort),
    .live(cnt_live), .reload(cnt_reload), .busy(busy), .start(start)
  );

  always_comb begin
    reg_rdata = '0;
    if (dbg_hit) begin
      reg_rdata = {{(DW-CW){1'b0}}, cnt_reload};
    end else if (win_hit) begin
      case (role)
        ROLE_RD:  reg_rdata = rd_ptr;
        ROLE_WR:  reg_rdata = wr_ptr;
        ROLE_CNT: reg_rdata = {{(DW-CW){1'b0}}, cnt_live};
        default:  reg_rdata = {{(DW-CTRL_W){1'b0}}, ctrl_q};
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic          rd_done,
  input logic          wr_done,
  input logic          abort,
  input logic          start,
  input logic          busy,
  input logic [DW-1:0] rd_ptr,
  input logic [DW-1:0] wr_ptr,
  input logic [CW-1:0] live
);
  // R3: a start pulse always comes with busy
  a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> busy);

  // R9: a start can only follow an idle cycle
  a_r9_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !$past(busy));

  // R6: busy falls only through the last write beat or an abort
  a_r6_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(abort) || ($past(wr_done) && $past(live) == CW'(1))));

  // R6: each write beat while busy counts down by one
  a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_done && !abort) |=> (live == $past(live) - CW'(1)));

  // R10: abort leaves the channel idle with an empty count
  a_r10_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && live == '0));

  // R7: idle strobes move no pointer
  a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !reg_we) |=> ($stable(rd_ptr) && $stable(wr_ptr)));
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .rd_done(rd_done), .wr_done(wr_done),
  .abort(abort), .start(start), .busy(busy), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
  .live(cnt_live)
);

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb;
  localparam int DW = 32, CW = 16, RA_W = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [RA_W-1:0] reg_addr = '0;
  logic            reg_we = 1'b0;
  logic [DW-1:0]   reg_wdata = '0;
  logic [DW-1:0]   reg_rdata;
  logic            rd_done = 1'b0, wr_done = 1'b0, abort = 1'b0;
  logic            start, busy;
  logic [DW-1:0]   rd_ptr, wr_ptr;

  int n_tests = 0, n_fail = 0;
  logic [31:0] m_rd = 0, m_wr = 0, m_ctrl = 0;
  int m_live = 0, m_reload = 0;

  always #2 clk = ~clk;

  dma_chan_regs #(.DW(DW), .CW(CW), .RA_W(RA_W)) u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bench's own view of the alias map: 0 rd, 1 wr, 2 count, 3 control
  function automatic int role(input int g, input int w);
    int tbl [16] = '{0,1,2,3, 3,0,1,2, 3,2,0,1, 3,1,2,0};
    return tbl[g*4+w];
  endfunction

  function automatic logic [31:0] model_read(input int a);
    if (a == 'h804) return m_reload;
    if (a >= 64) return 0;
    case (role(a/16, (a/4)%4))
      0: return m_rd;
      1: return m_wr;
      2: return m_live;
      default: return m_ctrl;
    endcase
  endfunction

  function automatic int stepb(input logic [1:0] c);
    return (c == 0) ? 1 : (c == 1) ? 2 : 4;
  endfunction

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk); reg_addr = RA_W'(a); reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    reg_addr = RA_W'(a); #1; d = reg_rdata;
  endtask

  task automatic strobe(input logic r, input logic w, input logic ab);
    @(negedge clk); rd_done = r; wr_done = w; abort = ab;
    @(negedge clk); rd_done = 0; wr_done = 0; abort = 0;
  endtask

  task automatic sweep(input string req);
    logic [31:0] d;
    for (int a = 0; a < 64; a += 4) begin
      bus_read(a, d); check(req, d, model_read(a));
    end
    bus_read('h804, d); check("R8", d, m_reload);
  endtask

  // apply a window write to the bench model (no trigger side effects)
  task automatic model_write(input int a, input logic [31:0] d);
    case (role(a/16, (a/4)%4))
      0: m_rd = d;
      1: m_wr = d;
      2: m_reload = int'(d[15:0]);
      default: m_ctrl = d & 32'hF;
    endcase
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    sweep("R1");
    check("R1", {start, busy}, 2'b00);
    check("R1", rd_ptr, 0); check("R1", wr_ptr, 0);

    // R2 / R4: every word of every group; trigger words written with zero
    for (int g = 0; g < 4; g++) begin
      for (int w = 0; w < 4; w++) begin
        int a = g*16 + w*4;
        logic [31:0] v = (w == 3) ? 32'h0 : (32'hA000_0000 | (g << 12) | (w << 8) | 32'h5C);
        bus_write(a, v);
        model_write(a, v);
        check(w == 3 ? "R4" : "R2", {start, busy}, 2'b00);
        sweep("R2");
      end
    end
    bus_read('h800, d); check("R2", d, 0);
    bus_read('h40, d);  check("R2", d, 0);
    bus_read('hFFC, d); check("R2", d, 0);

    // R7 / R6 / R3: runs of length 3 for every size code and increment setting
    for (int sz = 0; sz < 4; sz++) begin
      for (int inc = 0; inc < 4; inc++) begin
        m_ctrl = sz | (inc << 2);
        bus_write('h10, m_ctrl);          // control, no trigger
        bus_write('h04, 32'h0000_2000); m_wr = 32'h2000;
        bus_write('h08, 3); m_reload = 3; // count write: reload only (R5)
        check("R5", busy, 0);
        bus_write('h3C, 32'h0000_0100); m_rd = 32'h100; m_live = 3;
        check("R3", {start, busy}, 2'b11);
        sweep("R3");
        for (int k = 0; k < 3; k++) begin
          strobe(1, 0, 0);
          if (inc[0]) m_rd += stepb(sz[1:0]);
          check("R7", rd_ptr, m_rd);
          check("R3", start, 0);
          strobe(0, 1, 0);
          if (inc[1]) m_wr += stepb(sz[1:0]);
          m_live--;
          check("R7", wr_ptr, m_wr);
          bus_read('h08, d); check("R6", d, m_live);
        end
        check("R6", busy, 0);
        strobe(1, 1, 0);                  // idle strobes ignored
        check("R7", rd_ptr, m_rd); check("R7", wr_ptr, m_wr);
      end
    end

    // R5: count trigger loads live and reload together
    bus_write('h1C, 5); m_reload = 5; m_live = 5;
    check("R5", {start, busy}, 2'b11);
    sweep("R5");

    // R9: trigger while busy writes the register only
    bus_write('h2C, 32'h0000_7770); m_wr = 32'h7770;
    check("R9", start, 0);
    sweep("R9");
    strobe(0, 1, 0); m_live = 4;
    if (m_ctrl[3]) m_wr += stepb(m_ctrl[1:0]);
    sweep("R6");

    // R12: pointer write beats increment in the same cycle
    @(negedge clk); reg_addr = 'h00; reg_we = 1; reg_wdata = 32'h5550; rd_done = 1;
    @(negedge clk); reg_we = 0; rd_done = 0; m_rd = 32'h5550;
    check("R12", rd_ptr, m_rd);

    // R10: abort clears live and busy, keeps reload
    strobe(0, 0, 1); m_live = 0;
    check("R10", busy, 0);
    sweep("R10");

    // R8: retrigger repeats the stored length
    bus_write('h3C, 32'h0000_0400); m_rd = 32'h400; m_live = m_reload;
    check("R8", {start, busy}, 2'b11);
    sweep("R8");

    // R10: abort wins over a same-cycle trigger
    strobe(0, 0, 1); m_live = 0;
    @(negedge clk); reg_addr = 'h1C; reg_we = 1; reg_wdata = 9; abort = 1;
    @(negedge clk); reg_we = 0; abort = 0; m_reload = 9;
    check("R10", {start, busy}, 2'b00);
    sweep("R10");

    // R11: zero-length trigger does nothing
    bus_write('h08, 0); m_reload = 0;
    bus_write('h0C, 32'h0000_000F); m_ctrl = 32'hF;
    check("R11", {start, busy}, 2'b00);
    sweep("R11");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule